// File: doc/BRIEF.md
# Glitch-Free Fast/Slow Processor Clock Switch

This block drives a processor clock from one of two free-running, unrelated clocks. A fast clock is used when the `brake` request is high and a slow clock is used when it is low. A change of source never produces a runt pulse on the output. The block that decides when to brake sits outside this one and only drives the request level.

Two registers in series hold the current source code. Both registers are clocked by a staged clock, which is the fast clock in the two codes whose leading stage is high and the slow clock otherwise. The output is the fast clock in code 11 and the slow clock in code 00. In the two intermediate codes it is held at logic high. The code only changes on a rising edge of the staged clock, when the output is already high. A switch therefore shows up as one stretched high phase and never as a shortened low phase. An active-low reset presets both registers asynchronously, so the block comes out of reset running from the fast clock.

Top module: `clk_switch2`

## Requirements
- R1: While `rst_n` is low, both stages are preset high and `cpu_clk` follows `clk_fast`. The level of `brake` has no effect during reset.
- R2: With `brake` held high and the switch settled, `cpu_clk` equals `clk_fast` (code 11).
- R3: With `brake` held low and the switch settled, `cpu_clk` equals `clk_slow` (code 00).
- R4: Every low phase of `cpu_clk` lasts at least as long as the shorter of the two input clocks' low phases.
- R5: Every high phase of `cpu_clk` lasts at least as long as the shorter of the two input clocks' high phases.
- R6: After `brake` changes and then holds, `cpu_clk` follows the requested clock no later than the second rising edge of `clk_slow`. The code moves through an intermediate code and never jumps directly between 11 and 00.
- R7: In the intermediate codes 10 and 01 (leading stage, trailing stage), `cpu_clk` is held at logic high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast free-running source clock |
| clk_slow | input | 1 | Slow free-running source clock |
| brake | input | 1 | Source request: 1 selects fast, 0 selects slow |
| rst_n | input | 1 | Asynchronous active-low reset, presets to fast |
| cpu_clk | output | 1 | Switched processor clock |

## Verification
The bench times every high and low phase of `cpu_clk` in real time while `brake` toggles at random moments. This includes bursts of toggles that are shorter than a full switch sequence. A switch that changed source while the output was low, or that dropped the forced-high level in an intermediate code, would produce a short low or high phase, and the bench would flag it. After each settled request, the bench compares the output against the requested clock from the second slow rising edge onward. A switch that skipped a stage or stalled would show the wrong clock there. It also holds `brake` low during reset to confirm that the fast clock is still delivered.

// File: rtl/clk_switch2.sv
module clk_switch2 (
  input  logic clk_fast,
  input  logic clk_slow,
  input  logic brake,
  input  logic rst_n,
  output logic cpu_clk
);

  logic       hold_a;
  logic       hold_b;
  logic       stage_clk;
  logic [1:0] sel;

  assign sel = {hold_a, hold_b};

  always_comb begin
    case (sel)
      2'b11, 2'b10: stage_clk = clk_fast;
      default:      stage_clk = clk_slow;
    endcase
  end

  always_comb begin
    case (sel)
      2'b11:   cpu_clk = clk_fast;
      2'b00:   cpu_clk = clk_slow;
      default: cpu_clk = 1'b1;
    endcase
  end

  always_ff @(posedge stage_clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_a <= 1'b1;
      hold_b <= 1'b1;
    end else begin
      hold_a <= brake;
      hold_b <= hold_a;
    end
  end

endmodule

// File: rtl/clk_switch2_chk.sv
module clk_switch2_chk (
  input logic clk_fast,
  input logic clk_slow,
  input logic rst_n,
  input logic stage_clk,
  input logic hold_a,
  input logic hold_b,
  input logic cpu_clk
);

  always @(posedge clk_fast) begin
    if (!rst_n) begin
      a_r1_reset_preset: assert (hold_a && hold_b);
    end
  end

  a_r2_fast_path: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (hold_a && hold_b) |-> (cpu_clk == clk_fast));

  a_r3_slow_path: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (!hold_a && !hold_b) |-> (cpu_clk == clk_slow));

  a_r6_no_skip_down: assert property (@(posedge stage_clk) disable iff (!rst_n)
    (hold_a && hold_b) |=> (hold_a || hold_b));

  a_r6_no_skip_up: assert property (@(posedge stage_clk) disable iff (!rst_n)
    (!hold_a && !hold_b) |=> !(hold_a && hold_b));

  a_r7_mixed_high_f: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (hold_a != hold_b) |-> cpu_clk);

  a_r7_mixed_high_s: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (hold_a != hold_b) |-> cpu_clk);

endmodule

bind clk_switch2 clk_switch2_chk u_chk (.*);

// File: tb/clk_switch2_test.sv
`timescale 1ns/1ps
module clk_switch2_test;
  localparam real FAST_PERIOD_NS = 83.334;
  localparam real SLOW_PERIOD_NS = 279.33;
  localparam real MIN_HALF_NS    = FAST_PERIOD_NS / 2.0;
  localparam real TOL_NS         = 0.01;

  logic clk_fast = 1'b0;
  logic clk_slow = 1'b0;
  logic brake    = 1'b0;
  logic rst_n    = 1'b1;
  logic cpu_clk;

  int   n_run  = 0;
  int   n_fail = 0;
  bit   mon_en = 1'b0;

  clk_switch2 uut (.clk_fast(clk_fast), .clk_slow(clk_slow), .brake(brake),
                   .rst_n(rst_n), .cpu_clk(cpu_clk));

  initial forever #(FAST_PERIOD_NS / 2.0) clk_fast = ~clk_fast;
  initial begin
    #17.3;
    forever #(SLOW_PERIOD_NS / 2.0) clk_slow = ~clk_slow;
  end

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s at %0t", req, act, exp, $time);
    end
  endtask

  // Pulse-width reference: phases measured in real time
  realtime t_rise, t_fall;
  bit have_rise = 1'b0, have_fall = 1'b0;
  always @(posedge cpu_clk) begin
    if (mon_en && have_fall)
      chk(($realtime - t_fall) >= MIN_HALF_NS - TOL_NS, "R4 low phase",
          $sformatf("%0.3f", $realtime - t_fall), $sformatf(">=%0.3f", MIN_HALF_NS));
    t_rise = $realtime;
    have_rise = mon_en;
  end
  always @(negedge cpu_clk) begin
    if (mon_en && have_rise)
      chk(($realtime - t_rise) >= MIN_HALF_NS - TOL_NS, "R5 R7 high phase",
          $sformatf("%0.3f", $realtime - t_rise), $sformatf(">=%0.3f", MIN_HALF_NS));
    t_fall = $realtime;
    have_fall = mon_en;
  end

  task automatic follow(input bit want_fast, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      if (want_fast) @(posedge clk_fast); else @(posedge clk_slow);
      #5;
      chk(cpu_clk == 1'b1, req, $sformatf("%0b", cpu_clk), "1");
      if (want_fast) @(negedge clk_fast); else @(negedge clk_slow);
      #5;
      chk(cpu_clk == 1'b0, req, $sformatf("%0b", cpu_clk), "0");
    end
  endtask

  task automatic request(input bit val);
    #($urandom_range(1, 400) * 0.731);
    brake = val;
    repeat (2) @(posedge clk_slow);
    follow(val, 2, "R6 settle");
    follow(val, 5, val ? "R2 fast" : "R3 slow");
  endtask

  initial begin
    #(FAST_PERIOD_NS * 150000.0);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    brake = 1'b0;
    follow(1'b1, 4, "R1 reset brake low");
    brake = 1'b1;
    follow(1'b1, 2, "R1 reset brake high");
    brake = 1'b0;
    follow(1'b1, 2, "R1 reset brake low again");
    brake = 1'b1;
    #3.1 rst_n = 1'b1;
    mon_en = 1'b1;
    follow(1'b1, 4, "R2 after reset");
    for (int k = 0; k < 24; k++) request(k[0] ? 1'b1 : 1'b0);
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 12; j++) begin
        #($urandom_range(20, 330) * 1.013);
        brake = ~brake;
      end
      request(k[0]);
    end
    for (int k = 0; k < 10; k++) request(1'($urandom_range(0, 1)));
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule